// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Page Protection

This block caches page translations for a processor's memory pipeline. A request carries a virtual address and an access kind: load, store or instruction fetch. All entries are searched in parallel. The virtual page number is compared with every valid tag. When one matches, the entry's physical page number is joined with the untouched page offset. The entry's permissions are then checked against the access kind. Every response appears on registered outputs one clock after the request.

Each entry keeps a tag, a physical page number, a valid flag, a write-permission flag, an execute-permission flag, a dirty flag and a referenced flag. A request that finds no valid entry reports a miss and produces no translation. Software or a page walker then installs the missing mapping through a fill port. The fill port picks its victim in the block itself.

A flush input invalidates every entry at once. A clear input wipes all referenced flags, so that software can sample page usage over time. A debug index port reads back the dirty and referenced flags of any single entry.

Top module: `tlb_xlate`

## Requirements
- R1: For a request whose virtual page matches a valid entry that allows the access, the cycle after the request shows rsp_hit=1, rsp_fault=0 and rsp_cause=0. rsp_paddr then equals the entry's physical page number in bits [31:10], with the request's offset bits [9:0] unchanged.
- R2: For a request whose page matches no valid entry, the cycle after the request shows rsp_miss=1, rsp_hit=0, rsp_cause=1 and rsp_paddr=0.
- R3: A store (req_kind=2'b01) that hits an entry without write permission shows rsp_hit=1, rsp_fault=1, rsp_cause=2 and rsp_paddr=0. Loads (req_kind=2'b00 or 2'b11) never fault.
- R4: A fetch (req_kind=2'b10) that hits an entry without execute permission shows rsp_hit=1, rsp_fault=1, rsp_cause=3 and rsp_paddr=0.
- R5: A store that hits and is permitted sets that entry's dirty flag. Loads, fetches and faulting stores leave the dirty flag unchanged.
- R6: Any hit sets that entry's referenced flag, whether or not the access faults. Pulsing ref_clear clears every referenced flag. When a hit and ref_clear occur in the same cycle, the hit's flag is set.
- R7: A fill goes to the valid entry with the same virtual page if there is one. Otherwise it goes to the lowest-numbered invalid entry. If every entry is valid, it goes to the entry named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, only on fills that use it.
- R8: A flush invalidates every entry in one cycle, so later lookups miss. A fill in the same cycle as a flush is dropped.
- R9: In a cycle that follows one without req_valid, rsp_hit, rsp_miss, rsp_fault, rsp_cause and rsp_paddr are all zero.
- R10: A fill clears the dirty and referenced flags of the entry it writes and takes its permissions from fill_wr and fill_ex.
- R11: After reset, every entry is invalid and the dirty and referenced flags all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 load |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 22 | Virtual page number to install |
| fill_ppn | input | 22 | Physical page number to install |
| fill_wr | input | 1 | Write permission of the new entry |
| fill_ex | input | 1 | Execute permission of the new entry |
| flush | input | 1 | Invalidate all entries |
| ref_clear | input | 1 | Clear all referenced flags |
| dbg_idx | input | 4 | Entry selected for readback |
| dbg_dirty | output | 1 | Dirty flag of the selected entry |
| dbg_ref | output | 1 | Referenced flag of the selected entry |
| rsp_hit | output | 1 | A valid entry matched |
| rsp_miss | output | 1 | No valid entry matched |
| rsp_fault | output | 1 | Matched, but the access is not permitted |
| rsp_cause | output | 2 | 0 none, 1 miss, 2 store to read-only, 3 fetch from non-executable |
| rsp_paddr | output | 32 | Translated physical address, zero unless translated |

## Verification
The assertions check several rules on every clock cycle:
- hit and miss never occur together, and a fault only comes with a hit;
- every request is answered exactly once, and an idle cycle produces quiet outputs;
- a miss always carries cause 1;
- a store-permission fault only follows a store;
- a good translation carries the request's offset;
- after a flush no entry is valid, and after a reference clear no referenced flag is set.

Whether the right physical page comes back, which slot a fill evicts, and how the dirty and referenced flags of a given entry change can only be shown by the bench's scenarios. These are observed through translations and the debug readback port.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [VA_W-1:0]           req_vaddr,
  input  logic [1:0]                req_kind,
  input  logic                      fill_en,
  input  logic [VA_W-OFF_W-1:0]     fill_vpn,
  input  logic [PA_W-OFF_W-1:0]     fill_ppn,
  input  logic                      fill_wr,
  input  logic                      fill_ex,
  input  logic                      flush,
  input  logic                      ref_clear,
  input  logic [$clog2(ENTRIES)-1:0] dbg_idx,
  output logic                      dbg_dirty,
  output logic                      dbg_ref,
  output logic                      rsp_hit,
  output logic                      rsp_miss,
  output logic                      rsp_fault,
  output logic [1:0]                rsp_cause,
  output logic [PA_W-1:0]           rsp_paddr
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, dirty_q, ref_q, wr_q, ex_q;
  logic [IDX_W-1:0]   rr_q;

  logic [ENTRIES-1:0] hit_vec, fill_vec;
  logic [IDX_W-1:0]   hit_idx, victim;
  logic               use_rr;

  wire [VPN_W-1:0] req_vpn  = req_vaddr[VA_W-1:OFF_W];
  wire             any_hit  = |hit_vec;
  wire             is_store = req_kind == 2'b01;
  wire             is_fetch = req_kind == 2'b10;
  wire             deny_wr  = is_store && !wr_q[hit_idx];
  wire             deny_ex  = is_fetch && !ex_q[hit_idx];
  wire             fill_go  = fill_en && !flush;
  wire             look_hit = req_valid && any_hit;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g]  = valid_q[g] && (tag_q[g] == req_vpn);
    assign fill_vec[g] = valid_q[g] && (tag_q[g] == fill_vpn);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  always_comb begin
    victim = rr_q;
    use_rr = 1'b1;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) begin
        victim = IDX_W'(i);
        use_rr = 1'b0;
      end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (fill_vec[i]) begin
        victim = IDX_W'(i);
        use_rr = 1'b0;
      end
  end

  assign dbg_dirty = dirty_q[dbg_idx];
  assign dbg_ref   = ref_q[dbg_idx];

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[victim] <= fill_vpn;
      ppn_q[victim] <= fill_ppn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      ref_q   <= '0;
      wr_q    <= '0;
      ex_q    <= '0;
      rr_q    <= '0;
    end else begin
      if (flush) valid_q <= '0;
      if (ref_clear) ref_q <= '0;
      if (look_hit) begin
        ref_q[hit_idx] <= 1'b1;
        if (is_store && !deny_wr) dirty_q[hit_idx] <= 1'b1;
      end
      if (fill_go) begin
        valid_q[victim] <= 1'b1;
        dirty_q[victim] <= 1'b0;
        ref_q[victim]   <= 1'b0;
        wr_q[victim]    <= fill_wr;
        ex_q[victim]    <= fill_ex;
        if (use_rr) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= 2'd0;
      rsp_paddr <= '0;
    end else begin
      rsp_hit   <= look_hit;
      rsp_miss  <= req_valid && !any_hit;
      rsp_fault <= look_hit && (deny_wr || deny_ex);
      rsp_cause <= !req_valid             ? 2'd0 :
                   !any_hit               ? 2'd1 :
                   deny_wr                ? 2'd2 :
                   deny_ex                ? 2'd3 : 2'd0;
      rsp_paddr <= (look_hit && !deny_wr && !deny_ex)
                   ? {ppn_q[hit_idx], req_vaddr[OFF_W-1:0]} : '0;
    end
  end

  assert_hit_miss_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_miss));
  assert_fault_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit);
  assert_miss_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> rsp_cause == 2'd1);
  assert_wr_fault_is_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind != 2'b01 |=> rsp_cause != 2'd2);
  assert_one_answer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_hit ^ rsp_miss));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_hit && !rsp_miss && !rsp_fault && rsp_cause == 2'd0 && rsp_paddr == '0);
  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_hit && !rsp_fault) -> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_q == '0);
  assert_ref_wiped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_clear && !req_valid |=> ref_q == '0);
endmodule

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/1ps
module tlb_xlate_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [31:0] req_vaddr = 0;
  logic [1:0]  req_kind = 0;
  logic        fill_en = 0;
  logic [21:0] fill_vpn = 0;
  logic [21:0] fill_ppn = 0;
  logic        fill_wr = 0;
  logic        fill_ex = 0;
  logic        flush = 0;
  logic        ref_clear = 0;
  logic [3:0]  dbg_idx = 0;
  logic        dbg_dirty, dbg_ref, rsp_hit, rsp_miss, rsp_fault;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_paddr;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  tlb_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_wr(fill_wr), .fill_ex(fill_ex), .flush(flush), .ref_clear(ref_clear),
    .dbg_idx(dbg_idx), .dbg_dirty(dbg_dirty), .dbg_ref(dbg_ref), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic fill(input logic [21:0] vpn, input logic [21:0] ppn, input bit wr, input bit ex);
    @(negedge clk);
    fill_en = 1; fill_vpn = vpn; fill_ppn = ppn; fill_wr = wr; fill_ex = ex;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic lookup(input logic [21:0] vpn, input logic [9:0] off, input logic [1:0] kind);
    @(negedge clk);
    req_valid = 1; req_vaddr = {vpn, off}; req_kind = kind;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_rsp(input string tag, input bit h, input bit m, input bit f,
                            input logic [1:0] c, input logic [31:0] pa);
    check(rsp_hit == h,   {tag, " hit"},   rsp_hit, h);
    check(rsp_miss == m,  {tag, " miss"},  rsp_miss, m);
    check(rsp_fault == f, {tag, " fault"}, rsp_fault, f);
    check(rsp_cause == c, {tag, " cause"}, rsp_cause, c);
    check(rsp_paddr == pa, {tag, " paddr"}, rsp_paddr, pa);
  endtask

  task automatic dbg(input logic [3:0] idx, input bit d, input bit r, input string tag);
    dbg_idx = idx;
    #1;
    check(dbg_dirty == d, {tag, " dirty"}, dbg_dirty, d);
    check(dbg_ref == r,   {tag, " ref"},   dbg_ref, r);
  endtask

  task automatic t_reset();
    do_reset();
    expect_rsp("R11 reset outputs", 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) dbg(4'(i), 0, 0, "R11 reset flags");
    lookup(22'h1, 10'h0, 2'b00);
    expect_rsp("R11 empty lookup", 0, 1, 0, 1, 0);
  endtask

  task automatic t_translate();
    do_reset();
    fill(22'h12345, 22'h0ABCD, 1, 1);
    lookup(22'h12345, 10'h3FF, 2'b00);
    expect_rsp("R1 load", 1, 0, 0, 0, {22'h0ABCD, 10'h3FF});
    lookup(22'h12345, 10'h001, 2'b10);
    expect_rsp("R1 fetch", 1, 0, 0, 0, {22'h0ABCD, 10'h001});
    lookup(22'h12345, 10'h155, 2'b11);
    expect_rsp("R1 kind3 load", 1, 0, 0, 0, {22'h0ABCD, 10'h155});
    @(negedge clk);
    expect_rsp("R9 idle", 0, 0, 0, 0, 0);
  endtask

  task automatic t_miss();
    do_reset();
    fill(22'h00010, 22'h00020, 1, 1);
    lookup(22'h00011, 10'h2A, 2'b00);
    expect_rsp("R2 neighbour page", 0, 1, 0, 1, 0);
    @(negedge clk);
    expect_rsp("R9 after miss", 0, 0, 0, 0, 0);
  endtask

  task automatic t_rights();
    do_reset();
    fill(22'h00100, 22'h00200, 0, 0);
    lookup(22'h00100, 10'h10, 2'b01);
    expect_rsp("R3 store read-only", 1, 0, 1, 2, 0);
    lookup(22'h00100, 10'h10, 2'b10);
    expect_rsp("R4 fetch non-exec", 1, 0, 1, 3, 0);
    lookup(22'h00100, 10'h10, 2'b00);
    expect_rsp("R3 load read-only ok", 1, 0, 0, 0, {22'h00200, 10'h10});
    fill(22'h00101, 22'h00201, 1, 0);
    lookup(22'h00101, 10'h20, 2'b01);
    expect_rsp("R3 store writable", 1, 0, 0, 0, {22'h00201, 10'h20});
    lookup(22'h00101, 10'h20, 2'b10);
    expect_rsp("R4 fetch on rw page", 1, 0, 1, 3, 0);
  endtask

  task automatic t_dirty();
    do_reset();
    fill(22'h00A00, 22'h00B00, 1, 1);
    fill(22'h00A01, 22'h00B01, 0, 1);
    lookup(22'h00A00, 10'h0, 2'b00);
    dbg(0, 0, 1, "R5 load keeps clean");
    lookup(22'h00A00, 10'h0, 2'b10);
    dbg(0, 0, 1, "R5 fetch keeps clean");
    lookup(22'h00A00, 10'h0, 2'b01);
    dbg(0, 1, 1, "R5 store sets dirty");
    lookup(22'h00A01, 10'h0, 2'b01);
    dbg(1, 0, 1, "R5 faulting store clean");
    fill(22'h00A00, 22'h00C00, 0, 0);
    dbg(0, 0, 0, "R10 refill clears flags");
    dbg(2, 0, 0, "R7 same vpn reuses slot");
    lookup(22'h00A00, 10'h7, 2'b00);
    expect_rsp("R10 refill new ppn", 1, 0, 0, 0, {22'h00C00, 10'h7});
    lookup(22'h00A00, 10'h7, 2'b01);
    expect_rsp("R10 refill new rights", 1, 0, 1, 2, 0);
  endtask

  task automatic t_ref();
    do_reset();
    fill(22'h00300, 22'h00400, 1, 0);
    fill(22'h00301, 22'h00401, 1, 0);
    dbg(0, 0, 0, "R6 fresh ref");
    lookup(22'h00300, 10'h0, 2'b10);
    dbg(0, 0, 1, "R6 faulting hit sets ref");
    lookup(22'h00301, 10'h0, 2'b00);
    dbg(1, 0, 1, "R6 load sets ref");
    @(negedge clk);
    ref_clear = 1;
    @(negedge clk);
    ref_clear = 0;
    dbg(0, 0, 0, "R6 clear slot0");
    dbg(1, 0, 0, "R6 clear slot1");
    @(negedge clk);
    ref_clear = 1; req_valid = 1; req_vaddr = {22'h00301, 10'h0}; req_kind = 2'b00;
    @(negedge clk);
    ref_clear = 0; req_valid = 0;
    dbg(1, 0, 1, "R6 hit beats clear");
    dbg(0, 0, 0, "R6 other cleared");
  endtask

  task automatic t_victim();
    do_reset();
    for (int i = 0; i < 16; i++) fill(22'(100 + i), 22'(500 + i), 1, 1);
    fill(22'd200, 22'd5, 1, 1);
    fill(22'd201, 22'd6, 1, 1);
    lookup(22'd100, 10'h0, 2'b00);
    expect_rsp("R7 rr evicts slot0", 0, 1, 0, 1, 0);
    lookup(22'd101, 10'h0, 2'b00);
    expect_rsp("R7 rr evicts slot1", 0, 1, 0, 1, 0);
    lookup(22'd102, 10'h4, 2'b00);
    expect_rsp("R7 slot2 kept", 1, 0, 0, 0, {22'd502, 10'h4});
    lookup(22'd200, 10'h4, 2'b01);
    expect_rsp("R7 new entry", 1, 0, 0, 0, {22'd5, 10'h4});
    dbg(0, 1, 1, "R7 new entry in slot0");
    dbg(1, 0, 0, "R7 slot1 untouched");
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
    fill(22'd300, 22'd7, 1, 1);
    lookup(22'd300, 10'h0, 2'b01);
    dbg(0, 1, 1, "R7 lowest invalid after flush");
  endtask

  task automatic t_flush();
    do_reset();
    fill(22'h00700, 22'h00800, 1, 1);
    fill(22'h00701, 22'h00801, 1, 1);
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
    lookup(22'h00700, 10'h0, 2'b00);
    expect_rsp("R8 flushed a", 0, 1, 0, 1, 0);
    lookup(22'h00701, 10'h0, 2'b00);
    expect_rsp("R8 flushed b", 0, 1, 0, 1, 0);
    @(negedge clk);
    flush = 1; fill_en = 1; fill_vpn = 22'h00702; fill_ppn = 22'h00802; fill_wr = 1; fill_ex = 1;
    @(negedge clk);
    flush = 0; fill_en = 0;
    lookup(22'h00702, 10'h0, 2'b00);
    expect_rsp("R8 fill dropped", 0, 1, 0, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_translate();
    t_miss();
    t_rights();
    t_dirty();
    t_ref();
    t_victim();
    t_flush();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule